// File: doc/BRIEF.md
# Bus-Master DMA Channel Register and Control Block

This block is the register front end and transfer bookkeeping for one bus-master DMA channel sitting next to a SCSI protocol engine. A host reaches it through a 128-byte I/O window with 1-, 2- or 4-byte accesses at any byte offset. The lower 64 bytes are forwarded to the protocol engine. Eight 32-bit DMA registers live at 0x40–0x5C, and a bus-control word lives at 0x70. Partial writes are merged into the current word. Reads are shifted down by the byte offset and trimmed to the access size.

Writing the command register acts on the channel at once. Start copies the programmed count, address and descriptor pointer into the working copies, clears the status flags and enables the engine's data path. Idle disables that path. Abort sends the engine a one-cycle cancel pulse. Blast is stored but does nothing. On the memory side, the engine asks for a chunk of a given length and direction. The block either grants it, trimmed to the remaining count, and advances its counters, or refuses it when the direction is wrong. The engine's interrupt and the channel's completion flag are merged into one level interrupt.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset the command word is 0, the working count is 0, the working address is 0xFFFFFFFF, the working descriptor pointer is 0xFFFFFFFD, status is 0, and `irq`, `core_dma_en` and `core_cancel` are 0.
- R2: Window decode: offsets 0x00–0x3F go to the engine (`core_reg` = offset[5:2]). 0x40 + 4·k is DMA register k, in the order command, start count, start address, working count, working address, status, start descriptor, working descriptor. 0x70 is the bus-control word. Every other offset reads 0.
- R3: `bus_size` 0/1/2 means 1/2/4 bytes. A write replaces only the addressed bytes, starting at byte lane offset[1:0]. A read returns the word shifted right by 8·offset[1:0] and masked to the size. This applies to the engine window as well.
- R4: A command write with op field bits[1:0] = 3 (start) loads the working count, address and descriptor pointer from their start registers, clears all status bits, and sets `core_dma_en` one cycle later.
- R5: Op 0 (idle) clears `core_dma_en`. Op 2 (abort) raises `core_cancel` for exactly the cycle after the write. Op 1 (blast) changes neither the enable nor the counters.
- R6: Bus writes to the working count, working address and working descriptor registers are ignored.
- R7: Status bit 4 follows `core_irq` one cycle later. `irq` = status bit 4 OR (status bit 3 AND command bit 6).
- R8: When `core_irq` rises while the command op is start and the working count is 0, status bit 3 (done) is set in the same cycle as bit 4. Otherwise a rise does not set done.
- R9: If bus-control bit 24 is 0, reading status clears bits 1, 2 and 3 and writes to status are ignored. If it is 1, reads do not clear, and writing 1s to those bits clears them. `irq` follows the cleared state.
- R10: A request of direction matching command bit 7 (1 = device to memory) is granted one cycle later. The granted length is min(request, working count) and the grant address is the working address. The count then drops by that length and the address rises by it.
- R11: A request whose direction differs from command bit 7 is refused one cycle later and leaves the counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Host access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset in the I/O window |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, same cycle |
| core_sel | output | 1 | Access to the engine window |
| core_wr | output | 1 | Engine access is a write |
| core_reg | output | 4 | Engine register index |
| core_wdata | output | 32 | Merged full word for the engine |
| core_rdata | input | 32 | Current engine register word |
| core_irq | input | 1 | Engine interrupt level |
| core_dma_en | output | 1 | Engine data path enabled |
| core_cancel | output | 1 | One-cycle cancel of the engine's request |
| mem_req | input | 1 | Chunk transfer request |
| mem_to_mem | input | 1 | Request direction, 1 = device to memory |
| mem_len | input | 32 | Requested length in bytes |
| mem_gnt | output | 1 | Request granted |
| mem_refuse | output | 1 | Request refused |
| mem_gnt_addr | output | 32 | Memory address of the grant |
| mem_gnt_len | output | 32 | Granted length |
| irq | output | 1 | Merged level interrupt |

## Verification
Reads are combinational, so `bus_rdata` is sampled in the same cycle as the access. A register write, a command's effect on `core_dma_en`, and a grant or refusal all show up after one clock edge. The bench drives on the falling edge and samples one step after the next rising edge. The status flags and `irq` follow a change of `core_irq` one edge later. The bench uses the same single-edge wait before reading them back. It watches the cancel pulse in the cycle after the abort write and checks that it is gone a cycle later.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int REG_W      = 32;
    localparam int WIN_AW     = 7;
    localparam int CORE_IDX_W = 4;
    localparam int DMA_IDX_W  = 3;
    localparam int CMD_W      = 8;
    localparam int STAT_W     = 6;
    localparam int CTL_CLR_MODE = 24;
    localparam logic [WIN_AW-1:0] CTL_OFFSET = 7'h70;
    localparam logic [REG_W-1:0] WADDR_RST = 32'hFFFF_FFFF;
    localparam logic [REG_W-1:0] WDESC_RST = 32'hFFFF_FFFD;
    localparam logic [STAT_W-1:0] STAT_CLR_MASK = 6'b001110;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_BLAST = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } dma_op_e;

    typedef enum logic [DMA_IDX_W-1:0] {
        RI_CMD   = 3'd0,
        RI_SCNT  = 3'd1,
        RI_SADDR = 3'd2,
        RI_WCNT  = 3'd3,
        RI_WADDR = 3'd4,
        RI_STAT  = 3'd5,
        RI_SDESC = 3'd6,
        RI_WDESC = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic    dir;
        logic    done_ie;
        logic    page_ie;
        logic    desc_mode;
        logic    rsvd;
        logic    diag;
        dma_op_e op;
    } cmd_t;

    typedef struct packed {
        logic blast;
        logic scsi;
        logic done;
        logic abt;
        logic err;
        logic pwdn;
    } stat_t;

    function automatic logic [REG_W-1:0] lane_mask(input logic [1:0] size);
        case (size)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] merge_lanes(input logic [REG_W-1:0] cur,
                                                     input logic [REG_W-1:0] wdata,
                                                     input logic [1:0] off,
                                                     input logic [1:0] size);
        logic [REG_W-1:0] m;
        m = lane_mask(size) << {off, 3'b000};
        return (cur & ~m) | ((wdata << {off, 3'b000}) & m);
    endfunction

    function automatic logic [REG_W-1:0] align_read(input logic [REG_W-1:0] val,
                                                    input logic [1:0] off,
                                                    input logic [1:0] size);
        return (val >> {off, 3'b000}) & lane_mask(size);
    endfunction
endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
    import dmac_pkg::*;
(
    input  logic                  bus_req,
    input  logic                  bus_wr,
    input  logic [WIN_AW-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [REG_W-1:0]      bus_wdata,
    input  logic [REG_W-1:0]      core_rdata,
    input  logic [REG_W-1:0]      dma_cur,
    input  logic [REG_W-1:0]      ctl_cur,
    output logic [REG_W-1:0]      bus_rdata,
    output logic                  core_sel,
    output logic                  core_wr,
    output logic [CORE_IDX_W-1:0] core_reg,
    output logic                  dma_we,
    output logic                  dma_re,
    output logic [DMA_IDX_W-1:0]  dma_idx,
    output logic                  ctl_we,
    output logic [REG_W-1:0]      wr_word
);
    logic hit_core, hit_dma, hit_ctl;
    logic [REG_W-1:0] cur_word;

    assign hit_core = ~bus_addr[WIN_AW-1];
    assign hit_dma  = (bus_addr[WIN_AW-1:WIN_AW-2] == 2'b10);
    assign hit_ctl  = (bus_addr[WIN_AW-1:2] == CTL_OFFSET[WIN_AW-1:2]);

    always_comb begin
        if (hit_core)     cur_word = core_rdata;
        else if (hit_dma) cur_word = dma_cur;
        else if (hit_ctl) cur_word = ctl_cur;
        else              cur_word = '0;
    end

    assign wr_word   = merge_lanes(cur_word, bus_wdata, bus_addr[1:0], bus_size);
    assign bus_rdata = align_read(cur_word, bus_addr[1:0], bus_size);

    assign core_sel = bus_req & hit_core;
    assign core_wr  = bus_wr;
    assign core_reg = bus_addr[CORE_IDX_W+1:2];
    assign dma_idx  = bus_addr[DMA_IDX_W+1:2];
    assign dma_we   = bus_req & bus_wr & hit_dma;
    assign dma_re   = bus_req & ~bus_wr & hit_dma;
    assign ctl_we   = bus_req & bus_wr & hit_ctl;
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] ld_cnt,
    input  logic [REG_W-1:0] ld_addr,
    input  logic [REG_W-1:0] ld_desc,
    input  logic             cmd_dir,
    input  logic             req,
    input  logic             req_dir,
    input  logic [REG_W-1:0] req_len,
    output logic [REG_W-1:0] wcnt,
    output logic [REG_W-1:0] waddr,
    output logic [REG_W-1:0] wdesc,
    output logic             gnt,
    output logic             refuse,
    output logic [REG_W-1:0] gnt_addr,
    output logic [REG_W-1:0] gnt_len
);
    logic [REG_W-1:0] take;
    logic             dir_ok;

    assign take   = (req_len < wcnt) ? req_len : wcnt;
    assign dir_ok = (req_dir == cmd_dir);

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt     <= '0;
            waddr    <= WADDR_RST;
            wdesc    <= WDESC_RST;
            gnt      <= 1'b0;
            refuse   <= 1'b0;
            gnt_addr <= '0;
            gnt_len  <= '0;
        end else begin
            gnt    <= 1'b0;
            refuse <= 1'b0;
            if (load) begin
                wcnt  <= ld_cnt;
                waddr <= ld_addr;
                wdesc <= ld_desc;
            end else if (req) begin
                if (dir_ok) begin
                    gnt      <= 1'b1;
                    gnt_addr <= waddr;
                    gnt_len  <= take;
                    wcnt     <= wcnt - take;
                    waddr    <= waddr + take;
                end else begin
                    refuse <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dmac_status.sv
module dmac_status
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_clr,
    input  logic              w1c,
    input  logic [STAT_W-1:0] w1c_bits,
    input  logic              core_irq,
    input  logic              arm_done,
    input  logic              done_ie,
    output stat_t             stat,
    output logic              irq
);
    logic  core_q;
    stat_t stat_nxt;

    always_comb begin
        stat_nxt      = stat;
        stat_nxt.scsi = core_irq;
        if (rd_clr)
            stat_nxt = stat_t'(stat_nxt & ~STAT_CLR_MASK);
        if (w1c)
            stat_nxt = stat_t'(stat_nxt & ~(w1c_bits & STAT_CLR_MASK));
        if (core_irq && !core_q && arm_done)
            stat_nxt.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat   <= '0;
            core_q <= 1'b0;
        end else begin
            core_q <= core_irq;
            stat   <= start ? stat_t'('0) : stat_nxt;
        end
    end

    assign irq = stat.scsi | (stat.done & done_ie);
endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
    import dmac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_req,
    input  logic                  bus_wr,
    input  logic [WIN_AW-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    output logic                  core_sel,
    output logic                  core_wr,
    output logic [CORE_IDX_W-1:0] core_reg,
    output logic [REG_W-1:0]      core_wdata,
    input  logic [REG_W-1:0]      core_rdata,
    input  logic                  core_irq,
    output logic                  core_dma_en,
    output logic                  core_cancel,
    input  logic                  mem_req,
    input  logic                  mem_to_mem,
    input  logic [REG_W-1:0]      mem_len,
    output logic                  mem_gnt,
    output logic                  mem_refuse,
    output logic [REG_W-1:0]      mem_gnt_addr,
    output logic [REG_W-1:0]      mem_gnt_len,
    output logic                  irq
);
    cmd_t             cmd_q, cmd_new;
    stat_t            stat;
    logic [REG_W-1:0] scnt_q, saddr_q, sdesc_q, ctl_q;
    logic [REG_W-1:0] wcnt, waddr, wdesc;
    logic [REG_W-1:0] dma_cur, wr_word;
    logic [DMA_IDX_W-1:0] dma_idx;
    logic dma_we, dma_re, ctl_we;
    logic cmd_we, start_go, idle_go, abort_go, stat_rd_clr, stat_w1c;

    dmac_decode u_dec (
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .core_rdata(core_rdata), .dma_cur(dma_cur), .ctl_cur(ctl_q),
        .bus_rdata(bus_rdata), .core_sel(core_sel), .core_wr(core_wr), .core_reg(core_reg),
        .dma_we(dma_we), .dma_re(dma_re), .dma_idx(dma_idx), .ctl_we(ctl_we), .wr_word(wr_word)
    );

    assign core_wdata = wr_word;

    always_comb begin
        case (dma_idx)
            RI_CMD:   dma_cur = {{(REG_W-CMD_W){1'b0}}, cmd_q};
            RI_SCNT:  dma_cur = scnt_q;
            RI_SADDR: dma_cur = saddr_q;
            RI_WCNT:  dma_cur = wcnt;
            RI_WADDR: dma_cur = waddr;
            RI_STAT:  dma_cur = {{(REG_W-STAT_W){1'b0}}, stat};
            RI_SDESC: dma_cur = sdesc_q;
            default:  dma_cur = wdesc;
        endcase
    end

    assign cmd_new     = cmd_t'(wr_word[CMD_W-1:0]);
    assign cmd_we      = dma_we && (dma_idx == RI_CMD);
    assign start_go    = cmd_we && (cmd_new.op == OP_START);
    assign idle_go     = cmd_we && (cmd_new.op == OP_IDLE);
    assign abort_go    = cmd_we && (cmd_new.op == OP_ABORT);
    assign stat_rd_clr = dma_re && (dma_idx == RI_STAT) && !ctl_q[CTL_CLR_MODE];
    assign stat_w1c    = dma_we && (dma_idx == RI_STAT) && ctl_q[CTL_CLR_MODE];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q       <= '0;
            scnt_q      <= '0;
            saddr_q     <= '0;
            sdesc_q     <= '0;
            ctl_q       <= '0;
            core_dma_en <= 1'b0;
            core_cancel <= 1'b0;
        end else begin
            core_cancel <= abort_go;
            if (cmd_we) cmd_q <= cmd_new;
            if (dma_we && dma_idx == RI_SCNT)  scnt_q  <= wr_word;
            if (dma_we && dma_idx == RI_SADDR) saddr_q <= wr_word;
            if (dma_we && dma_idx == RI_SDESC) sdesc_q <= wr_word;
            if (ctl_we) ctl_q <= wr_word;
            if (start_go)     core_dma_en <= 1'b1;
            else if (idle_go) core_dma_en <= 1'b0;
        end
    end

    dmac_xfer u_xfer (
        .clk(clk), .rst(rst), .load(start_go),
        .ld_cnt(scnt_q), .ld_addr(saddr_q), .ld_desc(sdesc_q),
        .cmd_dir(cmd_q.dir), .req(mem_req), .req_dir(mem_to_mem), .req_len(mem_len),
        .wcnt(wcnt), .waddr(waddr), .wdesc(wdesc),
        .gnt(mem_gnt), .refuse(mem_refuse), .gnt_addr(mem_gnt_addr), .gnt_len(mem_gnt_len)
    );

    dmac_status u_stat (
        .clk(clk), .rst(rst), .start(start_go), .rd_clr(stat_rd_clr),
        .w1c(stat_w1c), .w1c_bits(wr_word[STAT_W-1:0]), .core_irq(core_irq),
        .arm_done((cmd_q.op == OP_START) && (wcnt == '0)), .done_ie(cmd_q.done_ie),
        .stat(stat), .irq(irq)
    );
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker
    import dmac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             core_irq,
    input logic             core_dma_en,
    input logic             core_cancel,
    input logic             mem_req,
    input logic             mem_to_mem,
    input logic [REG_W-1:0] mem_len,
    input logic             mem_gnt,
    input logic             mem_refuse,
    input logic [REG_W-1:0] mem_gnt_len,
    input logic             cmd_dir,
    input logic             start_go,
    input logic             abort_go
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !core_dma_en && !core_cancel));

    assert_enable_on_start_R4: assert property (@(posedge clk) disable iff (rst)
        start_go |=> core_dma_en);

    assert_cancel_after_abort_R5: assert property (@(posedge clk) disable iff (rst)
        core_cancel |-> $past(abort_go));

    assert_irq_follows_core_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(core_irq) && !$past(start_go) && !$past(rst)) |-> irq);

    assert_grant_bounded_R10: assert property (@(posedge clk) disable iff (rst)
        mem_gnt |-> (mem_gnt_len <= $past(mem_len)));

    assert_grant_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_gnt && mem_refuse));

    assert_refuse_dir_R11: assert property (@(posedge clk) disable iff (rst)
        mem_refuse |-> ($past(mem_req) && ($past(mem_to_mem) != $past(cmd_dir))));
endmodule

bind scsi_dma_chan dmac_checker u_chk (
    .clk(clk), .rst(rst), .irq(irq), .core_irq(core_irq),
    .core_dma_en(core_dma_en), .core_cancel(core_cancel),
    .mem_req(mem_req), .mem_to_mem(mem_to_mem), .mem_len(mem_len),
    .mem_gnt(mem_gnt), .mem_refuse(mem_refuse), .mem_gnt_len(mem_gnt_len),
    .cmd_dir(cmd_q.dir), .start_go(start_go), .abort_go(abort_go)
);

// File: tb/tb_scsi_dma_chan.sv
module tb_scsi_dma_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_sel, core_wr;
    logic [3:0]  core_reg;
    logic [31:0] core_wdata, core_rdata;
    logic        core_irq = 1'b0;
    logic        core_dma_en, core_cancel;
    logic        mem_req = 1'b0, mem_to_mem = 1'b0;
    logic [31:0] mem_len = '0;
    logic        mem_gnt, mem_refuse;
    logic [31:0] mem_gnt_addr, mem_gnt_len;
    logic        irq;

    logic [31:0] core_regs [16];
    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) core_regs[i] <= 32'h0;
        end else if (core_sel && core_wr) begin
            core_regs[core_reg] <= core_wdata;
        end
    end
    assign core_rdata = core_regs[core_reg];

    scsi_dma_chan dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(posedge clk); #1;
        bus_req = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [6:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1; bus_wr = 0; bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_req = 0;
    endtask

    task automatic expect_rd(input string tag, input logic [6:0] a, input logic [1:0] sz,
                             input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, sz, d);
        check(tag, d, exp);
    endtask

    logic        g_gnt, g_ref;
    logic [31:0] g_addr, g_len;
    task automatic grant(input logic dir, input logic [31:0] len);
        @(negedge clk);
        mem_req = 1; mem_to_mem = dir; mem_len = len;
        @(posedge clk); #1;
        mem_req = 0;
        g_gnt = mem_gnt; g_ref = mem_refuse; g_addr = mem_gnt_addr; g_len = mem_gnt_len;
    endtask

    task automatic set_core_irq(input logic v);
        @(negedge clk);
        core_irq = v;
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] model_take(input logic [31:0] len, input logic [31:0] cnt);
        return (len < cnt) ? len : cnt;
    endfunction

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 dma_en", {31'b0, core_dma_en}, 32'h0);
        expect_rd("R1 cmd", 7'h40, 2, 32'h0);
        expect_rd("R1 wcnt", 7'h4C, 2, 32'h0);
        expect_rd("R1 waddr", 7'h50, 2, 32'hFFFF_FFFF);
        expect_rd("R1 stat", 7'h54, 2, 32'h0);
        expect_rd("R1 wdesc", 7'h5C, 2, 32'hFFFF_FFFD);

        // R2 decode
        bus_write(7'h44, 2, 32'h1234_5678);
        expect_rd("R2 scnt", 7'h44, 2, 32'h1234_5678);
        bus_write(7'h48, 2, 32'hA5A5_0000);
        expect_rd("R2 saddr", 7'h48, 2, 32'hA5A5_0000);
        bus_write(7'h58, 2, 32'h0000_4400);
        expect_rd("R2 sdesc", 7'h58, 2, 32'h0000_4400);
        bus_write(7'h70, 2, 32'h0000_00C3);
        expect_rd("R2 ctl", 7'h70, 2, 32'h0000_00C3);
        expect_rd("R2 unmapped", 7'h64, 2, 32'h0);
        bus_write(7'h08, 2, 32'hCAFE_F00D);
        expect_rd("R2 core window", 7'h08, 2, 32'hCAFE_F00D);
        bus_write(7'h70, 2, 32'h0);

        // R3 sub-word merge and read alignment
        bus_write(7'h45, 0, 32'h0000_00AB);
        expect_rd("R3 byte merge", 7'h44, 2, 32'h1234_AB78);
        expect_rd("R3 half read", 7'h46, 1, 32'h0000_1234);
        expect_rd("R3 byte read", 7'h47, 0, 32'h0000_0012);
        bus_write(7'h0A, 1, 32'h0000_BEEF);
        expect_rd("R3 core merge", 7'h08, 2, 32'hBEEF_F00D);
        expect_rd("R3 core byte", 7'h09, 0, 32'h0000_00F0);

        // R6 working registers ignore writes
        bus_write(7'h4C, 2, 32'h1111_1111);
        bus_write(7'h50, 2, 32'h2222_2222);
        bus_write(7'h5C, 2, 32'h3333_3333);
        expect_rd("R6 wcnt", 7'h4C, 2, 32'h0);
        expect_rd("R6 waddr", 7'h50, 2, 32'hFFFF_FFFF);
        expect_rd("R6 wdesc", 7'h5C, 2, 32'hFFFF_FFFD);

        // R4 start
        bus_write(7'h44, 2, 32'd100);
        bus_write(7'h48, 2, 32'h0000_1000);
        bus_write(7'h58, 2, 32'h0000_2000);
        bus_write(7'h40, 2, 32'h0000_0043);
        check("R4 dma_en", {31'b0, core_dma_en}, 32'h1);
        expect_rd("R4 wcnt", 7'h4C, 2, 32'd100);
        expect_rd("R4 waddr", 7'h50, 2, 32'h0000_1000);
        expect_rd("R4 wdesc", 7'h5C, 2, 32'h0000_2000);
        expect_rd("R4 stat", 7'h54, 2, 32'h0);

        // R10 grants
        grant(0, 32'd30);
        check("R10 gnt", {31'b0, g_gnt}, 32'h1);
        check("R10 len", g_len, 32'd30);
        check("R10 addr", g_addr, 32'h0000_1000);
        expect_rd("R10 wcnt", 7'h4C, 2, 32'd70);
        expect_rd("R10 waddr", 7'h50, 2, 32'h0000_101E);
        // R11 wrong direction
        grant(1, 32'd10);
        check("R11 refuse", {31'b0, g_ref}, 32'h1);
        check("R11 no gnt", {31'b0, g_gnt}, 32'h0);
        expect_rd("R11 wcnt", 7'h4C, 2, 32'd70);
        grant(0, 32'd100);
        check("R10 trimmed len", g_len, 32'd70);
        check("R10 trimmed addr", g_addr, 32'h0000_101E);
        expect_rd("R10 wcnt zero", 7'h4C, 2, 32'd0);

        // R8 done on rise with count zero, R9 read-clear mode
        set_core_irq(1);
        check("R7 irq high", {31'b0, irq}, 32'h1);
        set_core_irq(0);
        check("R8 irq from done", {31'b0, irq}, 32'h1);
        expect_rd("R8 stat done", 7'h54, 2, 32'h08);
        check("R9 irq after read clear", {31'b0, irq}, 32'h0);
        expect_rd("R9 stat cleared", 7'h54, 2, 32'h0);

        // R9 write-one-to-clear mode
        bus_write(7'h70, 2, 32'h0100_0000);
        bus_write(7'h44, 2, 32'd0);
        bus_write(7'h40, 2, 32'h0000_0043);
        set_core_irq(1);
        set_core_irq(0);
        expect_rd("R9 w1c stat", 7'h54, 2, 32'h08);
        expect_rd("R9 no read clear", 7'h54, 2, 32'h08);
        bus_write(7'h54, 2, 32'h0);
        expect_rd("R9 zero write keeps", 7'h54, 2, 32'h08);
        bus_write(7'h54, 0, 32'h08);
        expect_rd("R9 w1c cleared", 7'h54, 2, 32'h0);
        check("R9 irq dropped", {31'b0, irq}, 32'h0);

        // R5 idle, R7 scsi bit without done
        bus_write(7'h40, 2, 32'h0000_0040);
        check("R5 idle disables", {31'b0, core_dma_en}, 32'h0);
        set_core_irq(1);
        check("R7 irq", {31'b0, irq}, 32'h1);
        expect_rd("R8 no done when idle", 7'h54, 2, 32'h10);
        set_core_irq(0);
        check("R7 irq low", {31'b0, irq}, 32'h0);

        // R5 blast and abort
        bus_write(7'h44, 2, 32'd50);
        bus_write(7'h40, 2, 32'h0000_0003);
        bus_write(7'h40, 0, 32'h0000_0001);
        check("R5 blast keeps enable", {31'b0, core_dma_en}, 32'h1);
        expect_rd("R5 blast keeps count", 7'h4C, 2, 32'd50);
        @(negedge clk);
        bus_req = 1; bus_wr = 1; bus_addr = 7'h40; bus_size = 0; bus_wdata = 32'h02;
        @(posedge clk); #1;
        bus_req = 0; bus_wr = 0;
        check("R5 cancel pulse", {31'b0, core_cancel}, 32'h1);
        @(posedge clk); #1;
        check("R5 cancel one cycle", {31'b0, core_cancel}, 32'h0);
        bus_write(7'h40, 2, 32'h0);
        bus_write(7'h70, 2, 32'h0);

        // R10 R11 constrained random transfers
        for (int it = 0; it < 30; it++) begin
            logic [31:0] cnt, addr, len, take;
            logic dir;
            cnt  = $urandom_range(0, 400);
            addr = $urandom;
            dir  = 1'($urandom_range(0, 1));
            bus_write(7'h44, 2, cnt);
            bus_write(7'h48, 2, addr);
            bus_write(7'h40, 2, {24'b0, dir, 7'b0000011});
            for (int k = 0; k < 4; k++) begin
                len = $urandom_range(0, 150);
                if ($urandom_range(0, 7) == 0) begin
                    grant(~dir, len);
                    check("R11 random refuse", {31'b0, g_ref}, 32'h1);
                end else begin
                    take = model_take(len, cnt);
                    grant(dir, len);
                    check("R10 random len", g_len, take);
                    check("R10 random addr", g_addr, addr);
                    cnt  = cnt - take;
                    addr = addr + take;
                end
            end
            expect_rd("R10 random wcnt", 7'h4C, 2, cnt);
            expect_rd("R10 random waddr", 7'h50, 2, addr);
        end

        finish_run();
    end
endmodule